// File: doc/BRIEF.md
# Sliding-Window 4x4 SAD Engine

This block is the matching datapath of a horizontal motion search. It compares one 4x4 block of the current picture with sixteen candidate positions in a reference strip. The candidate offsets run from -8 to +7 pixels. For each candidate it produces a sum of absolute differences (SAD). It also reports the lowest SAD, together with that candidate's index and its signed offset.

The surrounding logic pulses `start`. The engine then runs for sixteen cycles, four per block row. During a run the engine names the row it wants on `row_sel`. In the first cycle of each row the caller must present that row's four current pixels and the nineteen reference pixels that the row spans. The engine captures them and does not read those inputs again for that row. For the next three cycles it slides its private copy of the strip one pixel at a time. Four difference units evaluate four candidates in every cycle. A sixteen-entry buffer adds each row's partial sums into the total for its candidate. A one-cycle `done` pulse marks the point at which all sixteen totals are final. The results then stay on the outputs until the next run starts.

Top module: `sadw_engine`

## Requirements
- R1: After reset, `busy` and `done` are low, every SAD output is zero, `best_idx` is 0 and `row_sel` is 0.
- R2: A `start` sampled high while idle begins a run. `busy` is high for exactly 16 cycles after that edge. `done` is high for exactly one cycle, the cycle that follows the last busy cycle.
- R3: In run cycle t (0 to 15), `row_sel` equals t/4. `cur_row` and `ref_row` are sampled only in cycles where t mod 4 is 0. Their values in the other cycles have no effect on any result.
- R4: Pixel j of a packed input sits at bits [8j+7:8j]. Reference pixel p of a row lies at horizontal offset p-8 from the block's left edge. Candidate c (0 to 15, offset c-8) is reported at `sad_all[12c+11:12c]` and equals the sum over rows r and columns j of |cur[r][j] - ref[r][c+j]|.
- R5: Each SAD is 12 bits wide. The worst case of 16 x 255 = 4080 is reported exactly, without wrapping.
- R6: Starting a run clears the buffer, so no value from an earlier run affects the new results.
- R7: When `done` is high, `best_sad` is the smallest of the sixteen SADs and `best_idx` is that candidate's index. `best_off` equals `best_idx` - 8 in 5-bit two's complement.
- R8: When several candidates share the smallest SAD, the one with the lowest index is reported.
- R9: A `start` pulse during a run is ignored. The run keeps its length and its results.
- R10: After `done`, all SAD and best-candidate outputs hold their values until the next `start` is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run when idle |
| cur_row | input | 32 | Four current-block pixels of the selected row |
| ref_row | input | 152 | Nineteen reference pixels of the selected row |
| row_sel | output | 2 | Block row the engine is requesting (0 while idle) |
| busy | output | 1 | High during the sixteen run cycles |
| done | output | 1 | One-cycle pulse when all SADs are final |
| sad_all | output | 192 | Sixteen packed 12-bit SADs, candidate 0 in the low bits |
| best_sad | output | 12 | Lowest SAD |
| best_idx | output | 4 | Index of the lowest SAD |
| best_off | output | 5 | Signed offset of the lowest SAD (index - 8) |

## Verification
Let the clock edge at which `start` is sampled be edge 0. `busy` and `row_sel` then describe run cycle t during the low phase after edge t. Row data is consumed at edge t+1, and `done` together with the final SADs appears after edge 16. The bench drives and samples only on falling edges, so each check looks at the low phase in which its result is due. During those low phases the bench drives true row data on rows' first cycles and random junk at every other time. A stray `start` is injected partway through one run. After each `done`, the bench watches three idle cycles to confirm that the results hold.

// File: rtl/sadw_pkg.sv
package sadw_pkg;

    typedef enum logic {
        SW_IDLE = 1'b0,
        SW_RUN  = 1'b1
    } sw_state_e;

    // Bits needed to hold any value from 0 up to v inclusive.
    function automatic int unsigned width_for(input int unsigned v);
        return $clog2(v + 1);
    endfunction

endpackage

// File: rtl/sadw_window.sv
module sadw_window #(
    parameter int PIX_W    = 8,
    parameter int WIN_PIX  = 19,
    parameter int VIEW_PIX = 16,
    parameter int BLK      = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic                      step,
    input  logic [WIN_PIX*PIX_W-1:0]  ref_in,
    input  logic [BLK*PIX_W-1:0]      cur_in,
    output logic [VIEW_PIX*PIX_W-1:0] ref_view,
    output logic [BLK*PIX_W-1:0]      cur_view
);

    typedef struct packed {
        logic [WIN_PIX*PIX_W-1:0] win;
        logic [BLK*PIX_W-1:0]     cur;
    } win_t;

    win_t win_d, win_q;
    logic [WIN_PIX*PIX_W-1:0] strip;

    always_comb begin
        // The first cycle of a row bypasses the register, so capture costs no cycle.
        strip    = load ? ref_in : win_q.win;
        cur_view = load ? cur_in : win_q.cur;
        ref_view = strip[VIEW_PIX*PIX_W-1:0];
        win_d    = win_q;
        if (step) begin
            win_d.win = strip >> PIX_W;
            win_d.cur = cur_view;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

endmodule

// File: rtl/sadw_row_unit.sv
module sadw_row_unit #(
    parameter int PIX_W  = 8,
    parameter int BLK    = 4,
    parameter int RSAD_W = 10
) (
    input  logic [BLK*PIX_W-1:0] cur_px,
    input  logic [BLK*PIX_W-1:0] ref_px,
    output logic [RSAD_W-1:0]    row_sad
);

    logic [PIX_W-1:0] pa, pb, dif;

    always_comb begin
        row_sad = '0;
        pa      = '0;
        pb      = '0;
        dif     = '0;
        for (int j = 0; j < BLK; j++) begin
            pa      = cur_px[j*PIX_W +: PIX_W];
            pb      = ref_px[j*PIX_W +: PIX_W];
            dif     = (pa > pb) ? (pa - pb) : (pb - pa);
            row_sad = row_sad + RSAD_W'(dif);
        end
    end

endmodule

// File: rtl/sadw_accum.sv
module sadw_accum #(
    parameter int NCAND  = 16,
    parameter int NUNIT  = 4,
    parameter int STEPS  = 4,
    parameter int STEP_W = 2,
    parameter int RSAD_W = 10,
    parameter int SAD_W  = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     en,
    input  logic [STEP_W-1:0]        step_idx,
    input  logic [NUNIT*RSAD_W-1:0]  row_sads,
    output logic [NCAND*SAD_W-1:0]   sad_all
);

    typedef struct packed {
        logic [NCAND-1:0][SAD_W-1:0] acc;
    } acc_t;

    acc_t acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        for (int i = 0; i < NCAND; i++) begin
            if (clear) begin
                acc_d.acc[i] = '0;
            end else if (en && step_idx == STEP_W'(i % STEPS)) begin
                // Candidate i is served by unit i/STEPS in slide step i%STEPS.
                acc_d.acc[i] = acc_q.acc[i]
                             + SAD_W'(row_sads[(i / STEPS)*RSAD_W +: RSAD_W]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign sad_all = acc_q.acc;

endmodule

// File: rtl/sadw_best.sv
module sadw_best #(
    parameter int NCAND = 16,
    parameter int SAD_W = 12,
    parameter int IDX_W = 4
) (
    input  logic [NCAND*SAD_W-1:0] sad_all,
    output logic [SAD_W-1:0]       best_sad,
    output logic [IDX_W-1:0]       best_idx
);

    logic [SAD_W-1:0] run_min, cand;
    logic [IDX_W-1:0] run_idx;

    always_comb begin
        run_min = sad_all[SAD_W-1:0];
        run_idx = '0;
        cand    = '0;
        for (int i = 1; i < NCAND; i++) begin
            cand = sad_all[i*SAD_W +: SAD_W];
            // Strict compare keeps the earlier index on equal values.
            if (cand < run_min) begin
                run_min = cand;
                run_idx = IDX_W'(i);
            end
        end
        best_sad = run_min;
        best_idx = run_idx;
    end

endmodule

// File: rtl/sadw_engine.sv
module sadw_engine
    import sadw_pkg::*;
#(
    parameter  int PIX_W    = 8,
    parameter  int BLK      = 4,
    parameter  int NCAND    = 16,
    parameter  int NUNIT    = 4,
    localparam int STEPS    = NCAND / NUNIT,
    localparam int WIN_PIX  = NCAND + BLK - 1,
    localparam int VIEW_PIX = (NUNIT - 1) * STEPS + BLK,
    localparam int RSAD_W   = width_for(BLK * (2**PIX_W - 1)),
    localparam int SAD_W    = width_for(BLK * BLK * (2**PIX_W - 1)),
    localparam int IDX_W    = $clog2(NCAND),
    localparam int OFF_W    = IDX_W + 1,
    localparam int STEP_W   = (STEPS > 1) ? $clog2(STEPS) : 1,
    localparam int ROW_W    = (BLK > 1) ? $clog2(BLK) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [BLK*PIX_W-1:0]     cur_row,
    input  logic [WIN_PIX*PIX_W-1:0] ref_row,
    output logic [ROW_W-1:0]         row_sel,
    output logic                     busy,
    output logic                     done,
    output logic [NCAND*SAD_W-1:0]   sad_all,
    output logic [SAD_W-1:0]         best_sad,
    output logic [IDX_W-1:0]         best_idx,
    output logic signed [OFF_W-1:0]  best_off
);

    typedef struct packed {
        sw_state_e         state;
        logic [STEP_W-1:0] step;
        logic [ROW_W-1:0]  row;
        logic              done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic clear;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        clear      = 1'b0;
        case (ctl_q.state)
            SW_IDLE: begin
                if (start) begin
                    ctl_d.state = SW_RUN;
                    ctl_d.step  = '0;
                    ctl_d.row   = '0;
                    clear       = 1'b1;
                end
            end
            SW_RUN: begin
                if (ctl_q.step == STEP_W'(STEPS - 1)) begin
                    ctl_d.step = '0;
                    if (ctl_q.row == ROW_W'(BLK - 1)) begin
                        ctl_d.state = SW_IDLE;
                        ctl_d.done  = 1'b1;
                    end else begin
                        ctl_d.row = ctl_q.row + 1'b1;
                    end
                end else begin
                    ctl_d.step = ctl_q.step + 1'b1;
                end
            end
            default: ctl_d.state = SW_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{state: SW_IDLE, step: '0, row: '0, done: 1'b0};
        else        ctl_q <= ctl_d;
    end

    assign busy    = (ctl_q.state == SW_RUN);
    assign done    = ctl_q.done;
    assign row_sel = busy ? ctl_q.row : '0;

    logic                        win_load;
    logic [VIEW_PIX*PIX_W-1:0]   ref_view;
    logic [BLK*PIX_W-1:0]        cur_view;
    logic [NUNIT*RSAD_W-1:0]     row_sads;

    assign win_load = busy && (ctl_q.step == '0);

    sadw_window #(
        .PIX_W   (PIX_W),
        .WIN_PIX (WIN_PIX),
        .VIEW_PIX(VIEW_PIX),
        .BLK     (BLK)
    ) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (win_load),
        .step    (busy),
        .ref_in  (ref_row),
        .cur_in  (cur_row),
        .ref_view(ref_view),
        .cur_view(cur_view)
    );

    for (genvar u = 0; u < NUNIT; u++) begin : g_unit
        sadw_row_unit #(
            .PIX_W (PIX_W),
            .BLK   (BLK),
            .RSAD_W(RSAD_W)
        ) u_row (
            .cur_px (cur_view),
            .ref_px (ref_view[u*STEPS*PIX_W +: BLK*PIX_W]),
            .row_sad(row_sads[u*RSAD_W +: RSAD_W])
        );
    end

    sadw_accum #(
        .NCAND (NCAND),
        .NUNIT (NUNIT),
        .STEPS (STEPS),
        .STEP_W(STEP_W),
        .RSAD_W(RSAD_W),
        .SAD_W (SAD_W)
    ) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .en      (busy),
        .step_idx(ctl_q.step),
        .row_sads(row_sads),
        .sad_all (sad_all)
    );

    sadw_best #(
        .NCAND(NCAND),
        .SAD_W(SAD_W),
        .IDX_W(IDX_W)
    ) u_best (
        .sad_all (sad_all),
        .best_sad(best_sad),
        .best_idx(best_idx)
    );

    assign best_off = OFF_W'({1'b0, best_idx}) - OFF_W'(NCAND / 2);

endmodule

// File: rtl/sadw_engine_chk.sv
module sadw_engine_chk #(
    parameter int NCAND = 16,
    parameter int SAD_W = 12,
    parameter int IDX_W = 4,
    parameter int ROW_W = 2,
    parameter int CYC   = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start,
    input logic                   busy,
    input logic                   done,
    input logic [ROW_W-1:0]       row_sel,
    input logic [NCAND*SAD_W-1:0] sad_all,
    input logic [SAD_W-1:0]       best_sad,
    input logic [IDX_W-1:0]       best_idx
);

    localparam int LEN_W = $clog2(CYC + 2) + 1;
    logic [LEN_W-1:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    a_r2_run_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == LEN_W'(CYC)));

    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r2_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    a_r3_row_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (row_sel == '0));

    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !done) |=> (busy || done));

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(sad_all));

    always_ff @(posedge clk) begin
        if (rst_n && done) begin
            for (int i = 0; i < NCAND; i++) begin
                a_r7_min: assert (best_sad <= sad_all[i*SAD_W +: SAD_W]);
                a_r8_lowest_index: assert ((sad_all[i*SAD_W +: SAD_W] != best_sad)
                                           || (IDX_W'(i) >= best_idx));
            end
        end
    end

endmodule

bind sadw_engine sadw_engine_chk #(
    .NCAND(NCAND),
    .SAD_W(SAD_W),
    .IDX_W(IDX_W),
    .ROW_W(ROW_W),
    .CYC  (BLK * STEPS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .row_sel (row_sel),
    .sad_all (sad_all),
    .best_sad(best_sad),
    .best_idx(best_idx)
);

// File: tb/sadw_engine_test.sv
module sadw_engine_test;

    localparam int CLK_PERIOD = 10;
    localparam int NC   = 16;
    localparam int NR   = 4;
    localparam int NWIN = 19;
    localparam int SW   = 12;

    logic                clk = 1'b0;
    logic                rst_n;
    logic                start;
    logic [NR*8-1:0]     cur_row;
    logic [NWIN*8-1:0]   ref_row;
    logic [1:0]          row_sel;
    logic                busy, done;
    logic [NC*SW-1:0]    sad_all;
    logic [SW-1:0]       best_sad;
    logic [3:0]          best_idx;
    logic signed [4:0]   best_off;

    always #(CLK_PERIOD/2) clk = ~clk;

    sadw_engine uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cur_row(cur_row), .ref_row(ref_row),
        .row_sel(row_sel), .busy(busy), .done(done),
        .sad_all(sad_all), .best_sad(best_sad),
        .best_idx(best_idx), .best_off(best_off)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int cur_m [NR][NR];
    int ref_m [NR][NWIN];
    int exp_sad [NC];
    int exp_min, exp_idx;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [NR*8-1:0] pack_cur(input int r);
        logic [NR*8-1:0] v;
        for (int j = 0; j < NR; j++) v[j*8 +: 8] = 8'(cur_m[r][j]);
        return v;
    endfunction

    function automatic logic [NWIN*8-1:0] pack_ref(input int r);
        logic [NWIN*8-1:0] v;
        for (int p = 0; p < NWIN; p++) v[p*8 +: 8] = 8'(ref_m[r][p]);
        return v;
    endfunction

    task automatic drive_junk();
        for (int p = 0; p < NWIN; p++) ref_row[p*8 +: 8] = 8'($urandom);
        for (int j = 0; j < NR; j++)   cur_row[j*8 +: 8] = 8'($urandom);
    endtask

    // Model computed from R4, R7 and R8.
    task automatic build_model();
        for (int c = 0; c < NC; c++) begin
            exp_sad[c] = 0;
            for (int r = 0; r < NR; r++)
                for (int j = 0; j < NR; j++) begin
                    int d = cur_m[r][j] - ref_m[r][c+j];
                    exp_sad[c] += (d < 0) ? -d : d;
                end
        end
        exp_min = exp_sad[0];
        exp_idx = 0;
        for (int c = 1; c < NC; c++)
            if (exp_sad[c] < exp_min) begin
                exp_min = exp_sad[c];
                exp_idx = c;
            end
    endtask

    task automatic check_results(input string req, input string tag);
        for (int c = 0; c < NC; c++)
            check(sad_all[c*SW +: SW] == SW'(exp_sad[c]), req, {tag, " sad"},
                  sad_all[c*SW +: SW], exp_sad[c]);
    endtask

    // One full run; stray_t >= 0 pulses start during that run cycle (R9).
    task automatic run_engine(input string req, input string tag, input int stray_t);
        build_model();
        @(negedge clk);
        start = 1'b1;
        drive_junk();
        for (int t = 0; t < 16; t++) begin
            @(negedge clk);
            start = (t == stray_t);
            check(row_sel == 2'(t / 4), "R3", {tag, " row_sel"}, row_sel, t / 4);
            check(busy == 1'b1, "R2", {tag, " busy"}, busy, 1);
            check(done == 1'b0, "R2", {tag, " done early"}, done, 0);
            if (t % 4 == 0) begin
                cur_row = pack_cur(t / 4);
                ref_row = pack_ref(t / 4);
            end else begin
                drive_junk();   // R3: ignored outside a row's first cycle
            end
        end
        @(negedge clk);
        start = 1'b0;
        drive_junk();
        check(done == 1'b1, "R2", {tag, " done pulse"}, done, 1);
        check(busy == 1'b0, "R2", {tag, " busy end"}, busy, 0);
        check_results(req, tag);
        check(best_sad == SW'(exp_min), "R7", {tag, " best_sad"}, best_sad, exp_min);
        check(best_idx == 4'(exp_idx), "R8", {tag, " best_idx"}, best_idx, exp_idx);
        check(best_off == 5'(exp_idx - 8), "R7", {tag, " best_off"}, best_off, exp_idx - 8);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            drive_junk();
            check(done == 1'b0, "R2", {tag, " done once"}, done, 0);
        end
        check_results("R10", {tag, " hold"});
        check(best_idx == 4'(exp_idx), "R10", {tag, " best hold"}, best_idx, exp_idx);
    endtask

    task automatic t_reset();
        check(busy == 1'b0, "R1", "busy", busy, 0);
        check(done == 1'b0, "R1", "done", done, 0);
        check(row_sel == 2'd0, "R1", "row_sel", row_sel, 0);
        check(best_idx == 4'd0, "R1", "best_idx", best_idx, 0);
        check(sad_all == '0, "R1", "sads zero", (sad_all == '0) ? 0 : 1, 0);
    endtask

    task automatic t_random();
        for (int r = 0; r < NR; r++) begin
            for (int j = 0; j < NR; j++)   cur_m[r][j] = $urandom % 256;
            for (int p = 0; p < NWIN; p++) ref_m[r][p] = $urandom % 256;
        end
        run_engine("R4", "random", -1);
    endtask

    task automatic t_planted();
        for (int r = 0; r < NR; r++) begin
            for (int j = 0; j < NR; j++)   cur_m[r][j] = $urandom % 256;
            for (int p = 0; p < NWIN; p++) ref_m[r][p] = $urandom % 256;
            for (int j = 0; j < NR; j++)   ref_m[r][11+j] = cur_m[r][j];
        end
        run_engine("R7", "planted+3", -1);
    endtask

    task automatic t_tie();
        for (int r = 0; r < NR; r++) begin
            for (int j = 0; j < NR; j++) cur_m[r][j] = 100;
            for (int p = 0; p < NWIN; p++)
                ref_m[r][p] = ((p >= 5 && p <= 8) || (p >= 12 && p <= 15)) ? 100 : 0;
        end
        run_engine("R8", "tie", -1);
    endtask

    task automatic t_max();
        for (int r = 0; r < NR; r++) begin
            for (int j = 0; j < NR; j++)   cur_m[r][j] = 255;
            for (int p = 0; p < NWIN; p++) ref_m[r][p] = 0;
        end
        run_engine("R5", "max", -1);
    endtask

    task automatic t_clear();
        for (int r = 0; r < NR; r++) begin
            for (int j = 0; j < NR; j++)   cur_m[r][j] = 3 + j;
            for (int p = 0; p < NWIN; p++) ref_m[r][p] = (p + r) % 7;
        end
        run_engine("R6", "after max", -1);
    endtask

    task automatic t_stray_start();
        for (int r = 0; r < NR; r++) begin
            for (int j = 0; j < NR; j++)   cur_m[r][j] = $urandom % 256;
            for (int p = 0; p < NWIN; p++) ref_m[r][p] = $urandom % 256;
        end
        run_engine("R9", "stray start", 6);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n   = 1'b0;
        start   = 1'b0;
        cur_row = '0;
        ref_row = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_random();
        t_planted();
        t_tie();
        t_max();
        t_clear();
        t_stray_start();
        t_random();
        finish_run();
    end

endmodule